// File: doc/BRIEF.md
# Masked Pin Debounce Controller

This block filters a bank of general-purpose pins and publishes a clean bitmap of those pins configured as inputs. A direction mask marks the pins that are driven as outputs. Those bits are forced to zero before any comparison, so activity on an output pin never starts a debounce. A status reader samples the published bitmap whenever it needs it. A one-cycle strobe tells it when the bitmap has taken a new value.

A three-state machine does the work. In the compare state it watches the masked pins against a held candidate. In the wait state it counts down a fixed number of tick enables. In the recheck state it confirms the pins still match the candidate. A failed recheck captures the new reading and tries again. A separate retry counter limits how many tries are made. When the limit is reached the block raises a one-cycle give-up flag and leaves the published bitmap untouched.

Top module: `gpin_debounce`

## Requirements
- R1: After a synchronous active-high reset, `statusOut` is all zeros and `changeStrobe` and `giveUp` are low; the held candidate is also all zeros.
- R2: Pins whose `dirMask` bit is 1 are treated as 0 for every comparison, so toggling only those pins never changes `statusOut`, `changeStrobe` or `giveUp`.
- R3: While the masked pins equal the held candidate in the compare state, the machine stays there and the outputs do not change.
- R4: A mismatch in the compare state captures the masked pins as the candidate and starts a countdown of `DELAY_TICKS` tick enables. With `tickEn` high every cycle, the new value appears on `statusOut` after the clock edge `DELAY_TICKS + 1` cycles after the edge that saw the mismatch.
- R5: The countdown advances only on cycles with `tickEn` high; without ticks the machine waits indefinitely.
- R6: A recheck whose masked pins equal the candidate copies the candidate to `statusOut` and returns to the compare state.
- R7: A recheck whose masked pins differ from the candidate captures the new reading, restarts the full countdown and counts one retry.
- R8: A recheck that mismatches after `RETRY_MAX` retries have already been used pulses `giveUp` for exactly one cycle, returns to the compare state and leaves `statusOut` unchanged.
- R9: `changeStrobe` pulses for one cycle exactly when `statusOut` takes a value different from its previous one. A publish of an unchanged value gives no pulse.
- R10: `changeStrobe` and `giveUp` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pinsIn | input | NUM_PINS | Raw pin levels, already synchronous to `clk` |
| dirMask | input | NUM_PINS | 1 marks a pin configured as output |
| tickEn | input | 1 | One-cycle enable that advances the debounce countdown |
| statusOut | output | NUM_PINS | Published debounced input bitmap |
| changeStrobe | output | 1 | One-cycle pulse when `statusOut` changes value |
| giveUp | output | 1 | One-cycle pulse when the retry limit is exhausted |

## Verification
The assertions assume that `pinsIn`, `dirMask` and `tickEn` are already synchronous to `clk`. They also assume that reset is held across at least one rising edge before release. They place no constraint on how often the pins bounce or how the mask changes, because the properties only tie outputs and internal state to one another. The stimulus drives every input half a period away from the rising edge, holds reset for several cycles at the start, and mixes long steady stretches with fast bouncing and changing masks.

// File: rtl/gpin_debounce_pkg.sv
package gpin_debounce_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_WAIT    = 2'd1,
    ST_RECHECK = 2'd2
  } dbState_e;

  // Strobes from control to datapath, valid for one cycle each.
  typedef struct packed {
    logic capture;     // candidate <= masked pins
    logic startTimer;  // countdown <= DELAY_TICKS
    logic publish;     // status <= candidate
    logic clearRetry;  // retry count <= 0
    logic bumpRetry;   // retry count += 1
    logic abandon;     // give up: candidate <= status, pulse flag
  } dbCmd_t;

  // Conditions reported from datapath to control.
  typedef struct packed {
    logic mismatch;        // masked pins differ from candidate
    logic timerDone;       // last tick of the countdown this cycle
    logic retryExhausted;  // retry count reached its limit
  } dbFlag_t;

endpackage

// File: rtl/gpin_debounce_ctrl.sv
module gpin_debounce_ctrl
  import gpin_debounce_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  dbFlag_t  flags,
  output dbState_e fsmState,
  output dbCmd_t   cmd
);

  dbState_e stateQ;
  dbState_e stateD;

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_IDLE;
    else     stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    cmd    = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (flags.mismatch) begin
          cmd.capture    = 1'b1;
          cmd.startTimer = 1'b1;
          cmd.clearRetry = 1'b1;
          stateD         = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (flags.timerDone) stateD = ST_RECHECK;
      end
      ST_RECHECK: begin
        if (!flags.mismatch) begin
          cmd.publish = 1'b1;
          stateD      = ST_IDLE;
        end else if (flags.retryExhausted) begin
          cmd.abandon = 1'b1;
          stateD      = ST_IDLE;
        end else begin
          cmd.capture    = 1'b1;
          cmd.startTimer = 1'b1;
          cmd.bumpRetry  = 1'b1;
          stateD         = ST_WAIT;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  assign fsmState = stateQ;

endmodule

// File: rtl/gpin_debounce_dp.sv
module gpin_debounce_dp
  import gpin_debounce_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int DELAY_TICKS = 4,
  parameter int RETRY_MAX   = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pinsIn,
  input  logic [NUM_PINS-1:0] dirMask,
  input  logic                tickEn,
  input  dbCmd_t              cmd,
  output dbFlag_t             flags,
  output logic [NUM_PINS-1:0] candBits,
  output logic [NUM_PINS-1:0] statusOut,
  output logic                changeStrobe,
  output logic                giveUp
);

  localparam int CNT_W = $clog2(DELAY_TICKS + 1);
  localparam int RET_W = $clog2(RETRY_MAX + 2);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DELAY_TICKS);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [RET_W-1:0] RET_LIM  = RET_W'(RETRY_MAX);

  logic [NUM_PINS-1:0] maskedPins;
  logic [NUM_PINS-1:0] candQ;
  logic [NUM_PINS-1:0] statusQ;
  logic [CNT_W-1:0]    countQ;
  logic [RET_W-1:0]    retryQ;
  logic                strobeQ;
  logic                giveQ;

  // Output-configured pins read as zero.
  assign maskedPins = pinsIn & ~dirMask;

  assign flags.mismatch       = (maskedPins != candQ);
  assign flags.timerDone      = tickEn && (countQ == CNT_ONE);
  assign flags.retryExhausted = (retryQ == RET_LIM);

  // Candidate and published status.
  always_ff @(posedge clk) begin
    if (rst) begin
      candQ   <= '0;
      statusQ <= '0;
      strobeQ <= 1'b0;
    end else begin
      strobeQ <= 1'b0;
      if (cmd.capture)      candQ <= maskedPins;
      else if (cmd.abandon) candQ <= statusQ;
      if (cmd.publish) begin
        statusQ <= candQ;
        strobeQ <= (candQ != statusQ);
      end
    end
  end

  // One-shot countdown, advanced by tick enables.
  always_ff @(posedge clk) begin
    if (rst)                              countQ <= '0;
    else if (cmd.startTimer)              countQ <= CNT_LOAD;
    else if (tickEn && (countQ != '0))    countQ <= countQ - CNT_ONE;
  end

  // Retry counter, kept apart from the state encoding.
  always_ff @(posedge clk) begin
    if (rst)                 retryQ <= '0;
    else if (cmd.clearRetry) retryQ <= '0;
    else if (cmd.bumpRetry)  retryQ <= retryQ + RET_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) giveQ <= 1'b0;
    else     giveQ <= cmd.abandon;
  end

  assign candBits     = candQ;
  assign statusOut    = statusQ;
  assign changeStrobe = strobeQ;
  assign giveUp       = giveQ;

endmodule

// File: rtl/gpin_debounce.sv
module gpin_debounce
  import gpin_debounce_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int DELAY_TICKS = 4,
  parameter int RETRY_MAX   = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pinsIn,
  input  logic [NUM_PINS-1:0] dirMask,
  input  logic                tickEn,
  output logic [NUM_PINS-1:0] statusOut,
  output logic                changeStrobe,
  output logic                giveUp
);

  dbCmd_t              cmd;
  dbFlag_t             flags;
  dbState_e            fsmState;
  logic [NUM_PINS-1:0] candBits;

  gpin_debounce_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .flags    (flags),
    .fsmState (fsmState),
    .cmd      (cmd)
  );

  gpin_debounce_dp #(
    .NUM_PINS    (NUM_PINS),
    .DELAY_TICKS (DELAY_TICKS),
    .RETRY_MAX   (RETRY_MAX)
  ) u_dp (
    .clk          (clk),
    .rst          (rst),
    .pinsIn       (pinsIn),
    .dirMask      (dirMask),
    .tickEn       (tickEn),
    .cmd          (cmd),
    .flags        (flags),
    .candBits     (candBits),
    .statusOut    (statusOut),
    .changeStrobe (changeStrobe),
    .giveUp       (giveUp)
  );

endmodule

// File: rtl/gpin_debounce_chk.sv
module gpin_debounce_chk
  import gpin_debounce_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                tickEn,
  input dbState_e            fsmState,
  input logic [NUM_PINS-1:0] candBits,
  input logic [NUM_PINS-1:0] statusOut,
  input logic                changeStrobe,
  input logic                giveUp
);

  // R9: a strobe only accompanies a real change of value
  a_r9_strobe_on_change: assert property (@(posedge clk) disable iff (rst)
    changeStrobe |-> (statusOut != $past(statusOut)));

  // R9: every change of value carries a strobe
  a_r9_change_has_strobe: assert property (@(posedge clk) disable iff (rst)
    (statusOut != $past(statusOut)) |-> changeStrobe);

  // R8: giving up leaves the published bitmap alone
  a_r8_giveup_keeps_status: assert property (@(posedge clk) disable iff (rst)
    giveUp |-> (statusOut == $past(statusOut)));

  // R8: the give-up flag is a single-cycle pulse
  a_r8_giveup_single: assert property (@(posedge clk) disable iff (rst)
    giveUp |=> !giveUp);

  // R10: never both pulses together
  a_r10_pulses_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(giveUp && changeStrobe));

  // R3: in the compare state the candidate equals the published bitmap
  a_r3_idle_cand_matches: assert property (@(posedge clk) disable iff (rst)
    (fsmState == ST_IDLE) |-> (candBits == statusOut));

  // R5: no tick, no progress out of the wait state
  a_r5_wait_needs_tick: assert property (@(posedge clk) disable iff (rst)
    (fsmState == ST_WAIT && !tickEn) |=> (fsmState == ST_WAIT));

  // R6/R7: a recheck always resolves in one cycle
  a_r7_recheck_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (fsmState == ST_RECHECK) |=> (fsmState != ST_RECHECK));

endmodule

bind gpin_debounce gpin_debounce_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .tickEn       (tickEn),
  .fsmState     (fsmState),
  .candBits     (candBits),
  .statusOut    (statusOut),
  .changeStrobe (changeStrobe),
  .giveUp       (giveUp)
);

// File: tb/gpin_debounce_bench.sv
module gpin_debounce_bench;

  localparam int NP    = 8;
  localparam int DLY   = 4;
  localparam int RMAX  = 3;
  localparam int HALF  = 4;  // 125 MHz

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] pinsIn = '0;
  logic [NP-1:0] dirMask = '0;
  logic          tickEn = 1'b0;
  logic [NP-1:0] statusOut;
  logic          changeStrobe;
  logic          giveUp;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference state derived from the requirements.
  int            mState;   // 0 compare, 1 wait, 2 recheck
  logic [NP-1:0] mCand;
  logic [NP-1:0] mStatus;
  int            mCnt;
  int            mRet;
  logic          expStrobe;
  logic          expGive;
  int            giveSeen;

  always #HALF clk = ~clk;

  gpin_debounce #(.NUM_PINS(NP), .DELAY_TICKS(DLY), .RETRY_MAX(RMAX)) u_gpin_debounce (
    .clk(clk), .rst(rst), .pinsIn(pinsIn), .dirMask(dirMask), .tickEn(tickEn),
    .statusOut(statusOut), .changeStrobe(changeStrobe), .giveUp(giveUp)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void modelReset();
    mState = 0; mCand = '0; mStatus = '0; mCnt = 0; mRet = 0;
    expStrobe = 1'b0; expGive = 1'b0;
  endfunction

  function automatic void modelEdge(logic [NP-1:0] raw, logic [NP-1:0] dir, logic tk);
    logic [NP-1:0] m;
    m = raw & ~dir;
    expStrobe = 1'b0;
    expGive   = 1'b0;
    case (mState)
      0: if (m != mCand) begin
           mCand = m; mCnt = DLY; mRet = 0; mState = 1;
         end
      1: if (tk && mCnt == 1) begin
           mCnt = 0; mState = 2;
         end else if (tk && mCnt != 0) mCnt--;
      default: begin
        if (m == mCand) begin
          expStrobe = (mCand != mStatus);
          mStatus = mCand; mState = 0;
        end else if (mRet == RMAX) begin
          expGive = 1'b1; mCand = mStatus; mState = 0;
        end else begin
          mCand = m; mCnt = DLY; mRet++; mState = 1;
        end
      end
    endcase
  endfunction

  // One clock: drive at negedge, update model at posedge, compare after it.
  task automatic step(logic [NP-1:0] raw, logic [NP-1:0] dir, logic tk);
    @(negedge clk);
    pinsIn = raw; dirMask = dir; tickEn = tk;
    @(posedge clk);
    modelEdge(raw, dir, tk);
    #1;
    if (giveUp === 1'b1) giveSeen++;
    check("R4 R6 R7 status", 32'(statusOut), 32'(mStatus));
    check("R9 strobe", 32'(changeStrobe), 32'(expStrobe));
    check("R8 giveUp", 32'(giveUp), 32'(expGive));
    check("R10 exclusive", 32'(changeStrobe & giveUp), 32'd0);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; pinsIn = '0; dirMask = '0; tickEn = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    modelReset();
    giveSeen = 0;
  endtask

  initial begin
    logic [NP-1:0] raw;
    logic [NP-1:0] dir;
    int            hold;
    void'($urandom(32'd7411));
    modelReset();
    giveSeen = 0;
    repeat (3) @(negedge clk);
    // R1: outputs during and right after reset
    check("R1 status after reset", 32'(statusOut), 32'd0);
    check("R1 strobe after reset", 32'(changeStrobe), 32'd0);
    check("R1 giveUp after reset", 32'(giveUp), 32'd0);
    rst = 1'b0;

    // R2: only output pins toggle; nothing may happen
    for (int i = 0; i < 20; i++) step(NP'(i % 2 ? 8'hF0 : 8'hA0), 8'hF0, 1'b1);
    check("R2 masked toggles keep status", 32'(statusOut), 32'd0);

    // R3: steady inputs matching status
    for (int i = 0; i < 10; i++) step('0, '0, 1'b1);
    check("R3 steady idle", 32'(statusOut), 32'd0);

    // R4: exact latency with a tick every cycle
    step(8'h01, '0, 1'b1);
    for (int i = 0; i < DLY; i++) step(8'h01, '0, 1'b1);
    check("R4 not yet published", 32'(statusOut), 32'h00);
    step(8'h01, '0, 1'b1);
    check("R4 published after delay", 32'(statusOut), 32'h01);
    check("R6 strobe on publish", 32'(changeStrobe), 32'd1);

    // R5: countdown frozen without ticks
    doReset();
    step(8'h10, '0, 1'b0);
    for (int i = 0; i < 30; i++) step(8'h10, '0, 1'b0);
    check("R5 held without ticks", 32'(statusOut), 32'h00);
    for (int i = 0; i < DLY; i++) step(8'h10, '0, 1'b1);
    check("R5 not before recheck", 32'(statusOut), 32'h00);
    step(8'h10, '0, 1'b1);
    check("R5 published after ticks", 32'(statusOut), 32'h10);

    // R7 and R9: retry lands back on the old value, no strobe
    doReset();
    step(8'h01, '0, 1'b1);
    for (int i = 0; i < DLY; i++) step(8'h00, '0, 1'b1);
    step(8'h00, '0, 1'b1);
    check("R7 retry keeps status", 32'(statusOut), 32'h00);
    for (int i = 0; i < DLY; i++) step(8'h00, '0, 1'b1);
    step(8'h00, '0, 1'b1);
    check("R9 same-value publish status", 32'(statusOut), 32'h00);
    check("R9 same-value publish no strobe", 32'(changeStrobe), 32'd0);

    // R8: continuous bounce exhausts the retries
    doReset();
    for (int i = 0; i < 21; i++) step(i % 2 ? 8'h0C : 8'h03, '0, 1'b1);
    check("R8 giveUp at retry limit", 32'(giveUp), 32'd1);
    check("R8 status unchanged", 32'(statusOut), 32'h00);
    for (int i = 21; i < 25; i++) step(i % 2 ? 8'h0C : 8'h03, '0, 1'b1);
    check("R8 single pulse", 32'(giveSeen), 32'd1);

    // Constrained random mix
    doReset();
    raw = '0; dir = '0;
    for (int seg = 0; seg < 400; seg++) begin
      case ($urandom % 4)
        0: raw = NP'($urandom);
        1: raw = raw ^ (NP'(1) << ($urandom % NP));
        2: dir = ($urandom % 3 == 0) ? NP'($urandom) : '0;
        default: ;
      endcase
      hold = ($urandom % 2) ? 1 + int'($urandom % 3) : 8 + int'($urandom % 12);
      for (int k = 0; k < hold; k++) step(raw, dir, ($urandom % 4) != 0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(2 * HALF * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule